// File: doc/BRIEF.md
# Protected Quadrature Position Counter

This block turns the two phase signals of an incremental encoder into a signed-direction position count held in a `CNT_W`-bit register. Both phase inputs are first brought into the clock domain through a multi-flop synchroniser. Every edge of either phase is then decoded as one step forward, one step backward or an illegal jump. Legal steps pass through a power-of-two prescaler before they move the count. The count runs within a programmable window: a start value and a limit value, and it wraps between them in both directions.

Software reaches the block through a small word-addressed register port. Every configuration register sits behind a lock that is set out of reset. The lock is released by writing an unlock bit and set again by writing the lock flag. While it is set, the count can still be reloaded and the lock flag can still be written. Any write to the count register reloads the count with the start value and clears the prescaler, whatever data is written.

Register map (3-bit word address): 0 = control (bit0 run enable, bit1 unlock strobe, reads 0), 1 = status (bit0 lock flag, bit1 sticky phase error), 2 = start value, 3 = limit value, 4 = scale (bits 2:0 prescale code), 5 = decoder control (bit0 decoder enable), 6 = count.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset the lock flag (status bit0) reads 1. Count, start, scale, control and decoder control read 0, limit reads all ones, and the phase error (status bit1) reads 0.
- R2: While the lock flag is 1, writes to start (2), limit (3), scale (4), decoder control (5) and the run bit of control (0) leave those registers unchanged.
- R3: A control write with bit1 = 1 clears the lock flag. A status write with bit0 = 1 sets it, and this status write is accepted whether the lock is set or not.
- R4: With phases written {A,B}, the sequence 00→10→11→01→00 (A leading) moves the count up by one on every edge, and the reverse sequence moves it down by one on every edge.
- R5: The count moves only while both control bit0 (run) and decoder control bit0 (decode enable) are 1. If either is 0, phase edges leave the count unchanged.
- R6: When both phases change between two consecutive samples, the count does not move and status bit1 becomes 1. The bit stays 1 until software writes a status word with bit1 = 1.
- R7: Counting up from the limit value gives the start value. Counting down from the start value gives the limit value.
- R8: With scale code n (0 to 7), the count moves once per 2^n decoded steps. The move is taken in the direction of the step that completes the group.
- R9: Any write to the count register (6) loads the start value and clears the prescale accumulator, whatever the data. The write is accepted while the lock is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr (combinational) |

## Verification
The bench builds the block with its defaults: a 16-bit count, a 3-bit scale code and a two-stage synchroniser. The window registers are programmed to narrow ranges, such as 5 to 9 and 3 to 20, so that wraps in both directions occur within a few dozen edges. Random scale codes up to 3 bring the regrouping of steps, and direction changes in the middle of a group, within reach of a few hundred random phase moves. The random moves also include illegal double jumps.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

   typedef enum logic [2:0] {
      RA_CTRL  = 3'd0,
      RA_STAT  = 3'd1,
      RA_START = 3'd2,
      RA_LIMIT = 3'd3,
      RA_SCALE = 3'd4,
      RA_DEC   = 3'd5,
      RA_COUNT = 3'd6
   } reg_addr_e;

   typedef struct packed {
      logic up;
      logic dn;
      logic bad;
   } step_t;

endpackage

// File: rtl/qdc_sync.sv
module qdc_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (STAGES >= 2) else $error("qdc_sync: STAGES must be at least 2");
      assert (W >= 1) else $error("qdc_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/qdc_decode.sv
module qdc_decode
   import qdc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] ab,
   output step_t      step
);

   logic [1:0] prev_q;

   // Forward successor of a {A,B} state when A leads B.
   function automatic logic [1:0] fwd(input logic [1:0] s);
      return {~s[0], s[1]};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 2'b00;
      else        prev_q <= ab;
   end

   always_comb begin
      step = '0;
      if (en && (ab != prev_q)) begin
         if ((ab ^ prev_q) == 2'b11) step.bad = 1'b1;
         else if (ab == fwd(prev_q)) step.up  = 1'b1;
         else                         step.dn  = 1'b1;
      end
   end

   // R4/R6: a sample yields at most one kind of event
   a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({step.up, step.dn, step.bad}));

   // R5: nothing is decoded while disabled
   a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (step == '0));

endmodule

// File: rtl/qdc_prescale.sv
module qdc_prescale #(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            step_in,
   input  logic [PS_W-1:0] ps,
   output logic            adv
);

   localparam int ACC_W = (1 << PS_W) - 1;

   initial begin
      assert (PS_W >= 1 && PS_W <= 5) else $error("qdc_prescale: PS_W out of range");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] target;

   assign target = ACC_W'((32'd1 << ps) - 32'd1);
   assign adv    = step_in && (acc_q >= target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (clr)     acc_q <= '0;
      else if (step_in) acc_q <= adv ? '0 : acc_q + ACC_W'(1);
   end

   // R8: a completed group re-arms the accumulator
   a_r8_adv_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (acc_q == '0));

   // R9: a reload clears the accumulator
   a_r9_clr_acc: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0));

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
   import qdc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PS_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             phase_a,
   input  logic             phase_b,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   initial begin
      assert (CNT_W >= 4) else $error("quad_pos_counter: CNT_W too small");
      assert (PS_W < CNT_W) else $error("quad_pos_counter: PS_W must fit in bus");
   end

   // ---------------- phase path ----------------
   logic [1:0] ab_sync;
   step_t      step;
   logic       adv;
   logic       dec_on;

   qdc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({phase_a, phase_b}),
      .q     (ab_sync)
   );

   qdc_decode u_decode (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (dec_on),
      .ab    (ab_sync),
      .step  (step)
   );

   // ---------------- register state ----------------
   logic             run_q, dec_q, lock_q, err_q;
   logic [CNT_W-1:0] start_q, limit_q, count_q;
   logic [PS_W-1:0]  scale_q;

   logic wr;
   logic wr_ctrl, wr_stat, wr_start, wr_limit, wr_scale, wr_dec, wr_count;

   assign wr       = bus_sel && bus_wr;
   assign wr_ctrl  = wr && (bus_addr == RA_CTRL);
   assign wr_stat  = wr && (bus_addr == RA_STAT);
   assign wr_start = wr && (bus_addr == RA_START);
   assign wr_limit = wr && (bus_addr == RA_LIMIT);
   assign wr_scale = wr && (bus_addr == RA_SCALE);
   assign wr_dec   = wr && (bus_addr == RA_DEC);
   assign wr_count = wr && (bus_addr == RA_COUNT);

   assign dec_on = run_q && dec_q;

   qdc_prescale #(.PS_W(PS_W)) u_scale (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (wr_count),
      .step_in (step.up || step.dn),
      .ps      (scale_q),
      .adv     (adv)
   );

   // lock: set by status bit0, released by control bit1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       lock_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) lock_q <= 1'b1;
      else if (wr_ctrl && bus_wdata[1]) lock_q <= 1'b0;
   end

   // guarded configuration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         dec_q   <= 1'b0;
         start_q <= '0;
         limit_q <= '1;
         scale_q <= '0;
      end else if (!lock_q) begin
         if (wr_ctrl)  run_q   <= bus_wdata[0];
         if (wr_dec)   dec_q   <= bus_wdata[0];
         if (wr_start) start_q <= bus_wdata;
         if (wr_limit) limit_q <= bus_wdata;
         if (wr_scale) scale_q <= bus_wdata[PS_W-1:0];
      end
   end

   // sticky phase error
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       err_q <= 1'b0;
      else if (step.bad)                err_q <= 1'b1;
      else if (wr_stat && bus_wdata[1]) err_q <= 1'b0;
   end

   // position count with window wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (wr_count) begin
         count_q <= start_q;
      end else if (adv) begin
         if (step.up) count_q <= (count_q == limit_q) ? start_q : count_q + ONE;
         else         count_q <= (count_q == start_q) ? limit_q : count_q - ONE;
      end
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      case (reg_addr_e'(bus_addr))
         RA_CTRL:  bus_rdata[0] = run_q;
         RA_STAT:  begin bus_rdata[0] = lock_q; bus_rdata[1] = err_q; end
         RA_START: bus_rdata = start_q;
         RA_LIMIT: bus_rdata = limit_q;
         RA_SCALE: bus_rdata[PS_W-1:0] = scale_q;
         RA_DEC:   bus_rdata[0] = dec_q;
         RA_COUNT: bus_rdata = count_q;
         default:  bus_rdata = '0;
      endcase
   end

   // ---------------- assertions ----------------
   a_r2_locked_start: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start && lock_q) |=> $stable(start_q));

   a_r2_locked_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_limit && lock_q) |=> $stable(limit_q));

   a_r3_relock: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && bus_wdata[0]) |=> lock_q);

   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_on && !wr_count) |=> $stable(count_q));

   a_r6_bad_no_move: assert property (@(posedge clk) disable iff (!rst_n)
      (step.bad && !wr_count) |=> ($stable(count_q) && err_q));

   a_r7_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && step.up && (count_q == limit_q) && !wr_count) |=> (count_q == $past(start_q)));

   a_r9_count_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_count |=> (count_q == $past(start_q)));

endmodule

// File: tb/quad_pos_counter_bench.sv
module quad_pos_counter_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        phase_a, phase_b;
   logic        bus_sel, bus_wr;
   logic [2:0]  bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;

   always #2.5 clk = ~clk;

   quad_pos_counter u_quad_pos_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_a   (phase_a),
      .phase_b   (phase_b),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic        m_run, m_dec, m_lock, m_err;
   logic [15:0] m_start, m_limit, m_cnt;
   logic [2:0]  m_ps;
   int          m_acc;
   int          pos;

   function automatic logic [1:0] gray(input int p);
      case (p & 3)
         0:       return 2'b00;
         1:       return 2'b10;
         2:       return 2'b11;
         default: return 2'b01;
      endcase
   endfunction

   function automatic logic [15:0] next_cnt(input logic [15:0] c, input logic up,
                                            input logic [15:0] lo, input logic [15:0] hi);
      if (up) return (c == hi) ? lo : c + 16'd1;
      else    return (c == lo) ? hi : c - 16'd1;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_write(input logic [2:0] a, input logic [15:0] d);
      logic was_locked;
      was_locked = m_lock;
      case (a)
         3'd0: begin if (!was_locked) m_run = d[0]; if (d[1]) m_lock = 1'b0; end
         3'd1: begin if (d[0]) m_lock = 1'b1; if (d[1]) m_err = 1'b0; end
         3'd2: if (!was_locked) m_start = d;
         3'd3: if (!was_locked) m_limit = d;
         3'd4: if (!was_locked) m_ps = d[2:0];
         3'd5: if (!was_locked) m_dec = d[0];
         3'd6: begin m_cnt = m_start; m_acc = 0; end
         default: ;
      endcase
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
      logic [15:0] v;
      bus_read(a, v);
      chk(req, v, exp);
   endtask

   // delta 1 = forward, 3 = backward, 2 = illegal double jump
   task automatic move(input int delta);
      pos = (pos + delta) & 3;
      {phase_a, phase_b} = gray(pos);
      if (m_run && m_dec) begin
         if (delta == 2) m_err = 1'b1;
         else begin
            if (m_acc >= (1 << m_ps) - 1) begin
               m_acc = 0;
               m_cnt = next_cnt(m_cnt, delta == 1, m_start, m_limit);
            end else m_acc++;
         end
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      rst_n = 1'b0; phase_a = 1'b0; phase_b = 1'b0;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = '0;
      m_run = 0; m_dec = 0; m_lock = 1; m_err = 0;
      m_start = 16'h0000; m_limit = 16'hFFFF; m_cnt = 0; m_ps = 0; m_acc = 0; pos = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd_chk("R1 status", 3'd1, 16'h0001);
      rd_chk("R1 count",  3'd6, 16'h0000);
      rd_chk("R1 limit",  3'd3, 16'hFFFF);
      rd_chk("R1 start",  3'd2, 16'h0000);
      rd_chk("R1 scale",  3'd4, 16'h0000);
      rd_chk("R1 ctrl",   3'd0, 16'h0000);
      rd_chk("R1 dec",    3'd5, 16'h0000);

      // R2 locked writes ignored
      bus_write(3'd2, 16'h0005);
      bus_write(3'd3, 16'h0009);
      bus_write(3'd4, 16'h0002);
      bus_write(3'd5, 16'h0001);
      bus_write(3'd0, 16'h0001);
      rd_chk("R2 start held", 3'd2, 16'h0000);
      rd_chk("R2 limit held", 3'd3, 16'hFFFF);
      rd_chk("R2 scale held", 3'd4, 16'h0000);
      rd_chk("R2 dec held",   3'd5, 16'h0000);
      rd_chk("R2 ctrl held",  3'd0, 16'h0000);
      move(1);
      rd_chk("R5 no count while off", 3'd6, 16'h0000);

      // R3 unlock then configure
      bus_write(3'd0, 16'h0002);
      rd_chk("R3 unlocked", 3'd1, 16'h0000);
      bus_write(3'd2, 16'h0005);
      bus_write(3'd3, 16'h0009);
      bus_write(3'd5, 16'h0001);
      bus_write(3'd0, 16'h0001);
      rd_chk("R3 start set", 3'd2, 16'h0005);
      rd_chk("R3 ctrl set",  3'd0, 16'h0001);

      // R9 reload ignores data
      bus_write(3'd6, 16'hABCD);
      rd_chk("R9 reload", 3'd6, m_cnt);
      chk("R9 reload value", m_cnt, 16'h0005);

      // R4 forward and backward
      for (int i = 0; i < 3; i++) move(1);
      rd_chk("R4 forward x3", 3'd6, 16'h0008);
      move(3);
      rd_chk("R4 backward", 3'd6, 16'h0007);

      // R7 wraps
      move(1); move(1);
      rd_chk("R7 at limit", 3'd6, 16'h0009);
      move(1);
      rd_chk("R7 up wrap", 3'd6, 16'h0005);
      move(3);
      rd_chk("R7 down wrap", 3'd6, 16'h0009);

      // R5 gating by decoder enable
      bus_write(3'd5, 16'h0000);
      move(1); move(1);
      rd_chk("R5 held dec off", 3'd6, 16'h0009);
      bus_write(3'd5, 16'h0001);

      // R6 illegal jump
      move(2);
      rd_chk("R6 no move", 3'd6, 16'h0009);
      rd_chk("R6 err set", 3'd1, 16'h0002);
      move(1);
      rd_chk("R6 err sticky", 3'd1, 16'h0002);
      rd_chk("R6 count after", 3'd6, m_cnt);
      bus_write(3'd1, 16'h0002);
      rd_chk("R6 err cleared", 3'd1, 16'h0000);

      // R8 prescale by 4
      bus_write(3'd4, 16'h0002);
      bus_write(3'd6, 16'h0000);
      for (int i = 0; i < 3; i++) move(1);
      rd_chk("R8 group open", 3'd6, 16'h0005);
      move(1);
      rd_chk("R8 group done", 3'd6, 16'h0006);

      // R3 relock, R2 and R9 while locked
      bus_write(3'd1, 16'h0001);
      rd_chk("R3 relocked", 3'd1, 16'h0001);
      bus_write(3'd3, 16'h0064);
      rd_chk("R2 limit locked", 3'd3, 16'h0009);
      move(1);
      bus_write(3'd6, 16'h1234);
      rd_chk("R9 reload while locked", 3'd6, 16'h0005);

      // random phase walk
      bus_write(3'd0, 16'h0003);
      bus_write(3'd2, 16'h0003);
      bus_write(3'd3, 16'h0014);
      bus_write(3'd6, 16'h0000);
      for (int blk = 0; blk < 6; blk++) begin
         bus_write(3'd4, 16'($urandom_range(0, 3)));
         for (int k = 0; k < 100; k++) begin
            int r;
            r = $urandom_range(0, 19);
            if (r == 0)      move(2);
            else if (r < 11) move(1);
            else             move(3);
            rd_chk("R4 R7 R8 random walk", 3'd6, m_cnt);
         end
         rd_chk("R6 random status", 3'd1, {14'd0, m_err, m_lock});
         bus_write(3'd1, 16'h0002);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule